// File: doc/BRIEF.md
# Quad Serial DAC Write Controller

This block sits on the host side of a four-channel, 12-bit serial converter. A requester presents a 2-bit channel number and a 12-bit code with a one-cycle valid strobe. The controller builds a 16-bit word from them and shifts it out, most significant bit first, over a serial clock that idles high. The word holds the channel first, then two zero bits, then the code. The serial data changes while the clock is low, so each bit is stable when the clock rises.

In the default mode the controller lowers the active-low select before the first clock and raises it only after the clock has returned high after the sixteenth rising edge. It then gives a separate active-low load pulse. In the auto-load variant (`AUTO_LOAD = 1`) the select stays low all the time, and the load pulse is given during the low half of a seventeenth clock period. A `busy` level and a one-cycle `done` pulse form the handshake to the requester.

A separate clear request drives an active-low clear pulse of fixed width. The clear-select level holds the chosen preset: 1 selects midscale and 0 selects zero scale. The clear path runs apart from the write engine. All serial timings are parameters given as counts of the system clock.

Top module: `dac_wr_ctrl`

## Requirements
- R1: After a synchronous reset, `sclk`=1, `sdo`=0, `ld_n`=1, `clr_n`=1, `clsel`=0, `busy`=0 and `done`=0. `cs_n` is 1 in the default mode and 0 in auto-load mode.
- R2: The frame is 16 bits, sent first bit first: `wr_chan[1]`, `wr_chan[0]`, 0, 0, then `wr_code[11]` down to `wr_code[0]`. `sdo` holds each bit for one whole clock period: through the low phase and through the rising edge. Outside a frame `sdo` is 0.
- R3: Each serial period is `SCK_LO` system cycles with `sclk` low, followed by `SCK_HI` cycles with `sclk` high. A frame has exactly 16 such periods.
- R4: In the default mode, `cs_n` falls in the cycle after a request is accepted. It stays low for `CS_SETUP` cycles with `sclk` high before the first low phase. It rises one cycle after the 16th high phase ends, while `sclk` is high, and `sclk` is never low while `cs_n` is high.
- R5: In the default mode, `ld_n` goes low one cycle after `cs_n` rises and stays low for `LD_W` cycles. `ld_n` is never low while `cs_n` is low.
- R6: In auto-load mode, `cs_n` stays at 0 and there is no setup phase. After the 16th high phase, a 17th period holds `sclk`=0 and `ld_n`=0 for `LD_W` cycles, then `sclk`=1 and `ld_n`=1 for `SCK_HI` cycles.
- R7: `busy` is 1 from the cycle after acceptance until the cycle in which `ld_n` has returned high and the frame ends. `done` is 1 for exactly that single following cycle, with `busy` at 0.
- R8: A write request that arrives while `busy` is 1 is ignored. Its channel and code never appear on `sdo`.
- R9: A clear request drives `clr_n` low for `CLR_W` cycles, starting the cycle after it is accepted. `clsel` takes `clr_mid` in that same cycle and holds that value until the next accepted clear. A clear request made while `clr_n` is low is ignored.
- R10: A clear request is accepted and carried out while a frame is in progress, and it leaves that frame's serial, select, load and handshake outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_req | input | 1 | Write request strobe |
| wr_chan | input | 2 | Channel number of the write |
| wr_code | input | 12 | Converter code of the write |
| clr_req | input | 1 | Clear request strobe |
| clr_mid | input | 1 | Preset choice for the clear: 1 midscale, 0 zero |
| busy | output | 1 | Write frame in progress |
| done | output | 1 | One-cycle pulse when a write finishes |
| sclk | output | 1 | Serial clock, idles high |
| sdo | output | 1 | Serial data |
| cs_n | output | 1 | Active-low chip select |
| ld_n | output | 1 | Active-low load strobe |
| clr_n | output | 1 | Active-low clear pulse |
| clsel | output | 1 | Clear preset select level |

## Verification
The assertions assume that every timing parameter is at least one cycle. They also assume that requests are plain strobes sampled on the system clock, which may be held high or repeated freely, because the block itself ignores extra ones.

The stimulus keeps the default timings and drives all inputs half a cycle away from the active edge. It deliberately holds the write request high across whole frames and sends clear requests in the middle of frames and in the middle of other clear pulses. In every case the expected traces are those of the ignore rules in R8 and R9.

// File: rtl/dac_wr_pkg.sv
// Package: shared types and helpers for the serial DAC write controller.
// Assumes a 16-bit frame: 2 channel bits, 2 zero fill bits, 12 code bits.
package dac_wr_pkg;

    localparam int FRAME_BITS = 16;
    localparam int CHAN_BITS  = 2;
    localparam int CODE_BITS  = 12;
    localparam int FILL_BITS  = FRAME_BITS - CHAN_BITS - CODE_BITS;

    typedef enum logic [2:0] {
        ENG_IDLE,
        ENG_SETUP,
        ENG_LOW,
        ENG_HIGH,
        ENG_GAP,
        ENG_LOAD,
        ENG_TAIL
    } eng_state_t;

    // Assemble the shift word, first-sent bit at the top.
    function automatic logic [FRAME_BITS-1:0] pack_frame(
        input logic [CHAN_BITS-1:0] chan,
        input logic [CODE_BITS-1:0] code
    );
        return {chan, {FILL_BITS{1'b0}}, code};
    endfunction

    // Largest of four cycle counts, used to size timers.
    function automatic int max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/dac_clear_pulser.sv
// Module: dac_clear_pulser
// Issues a fixed-width active-low clear pulse and latches the preset select.
// Assumes CLR_W >= 1; requests during an active pulse are dropped.
module dac_clear_pulser #(
    parameter int CLR_W = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic mid,
    output logic clr_n,
    output logic sel
);
    localparam int CW = $clog2(CLR_W + 1);

    logic          active;
    logic [CW-1:0] left;

    // Pulse timer and preset latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            left   <= '0;
            sel    <= 1'b0;
        end else if (!active) begin
            if (req) begin
                active <= 1'b1;
                left   <= CW'(CLR_W - 1);
                sel    <= mid;
            end
        end else if (left == '0) begin
            active <= 1'b0;
        end else begin
            left <= left - 1'b1;
        end
    end

    // Output level of the clear pin.
    always_comb clr_n = ~active;

endmodule

// File: rtl/dac_frame_engine.sv
// Module: dac_frame_engine
// Serialises one 16-bit word with an idle-high clock, then strobes load.
// AUTO_LOAD=0: select framed around the word, load pulsed after select rises.
// AUTO_LOAD=1: select held low, load pulsed in the low half of a 17th period.
// Assumes every cycle-count parameter is at least 1; start is ignored while busy.
module dac_frame_engine
    import dac_wr_pkg::*;
#(
    parameter int SCK_LO    = 12,
    parameter int SCK_HI    = 9,
    parameter int CS_SETUP  = 9,
    parameter int LD_W      = 8,
    parameter bit AUTO_LOAD = 1'b0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [FRAME_BITS-1:0] word,
    output logic                  sclk,
    output logic                  sdo,
    output logic                  cs_n,
    output logic                  ld_n,
    output logic                  busy,
    output logic                  done
);
    localparam int TMAX = max4(SCK_LO, SCK_HI, CS_SETUP, LD_W);
    localparam int TW   = $clog2(TMAX + 1);
    localparam int BW   = $clog2(FRAME_BITS);

    eng_state_t            state;
    logic [TW-1:0]         timer;
    logic [BW-1:0]         bit_ix;
    logic [FRAME_BITS-1:0] shreg;
    logic                  tdone;
    logic                  last_bit;

    // Phase timer expiry and last-bit flag.
    always_comb begin
        tdone    = (timer == '0);
        last_bit = (bit_ix == BW'(FRAME_BITS - 1));
    end

    // Sequencer: phases, bit counter, shift register and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ENG_IDLE;
            timer  <= '0;
            bit_ix <= '0;
            shreg  <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ENG_IDLE: begin
                    if (start) begin
                        shreg  <= word;
                        bit_ix <= '0;
                        if (AUTO_LOAD) begin
                            state <= ENG_LOW;
                            timer <= TW'(SCK_LO - 1);
                        end else begin
                            state <= ENG_SETUP;
                            timer <= TW'(CS_SETUP - 1);
                        end
                    end
                end
                ENG_SETUP: begin
                    if (tdone) begin
                        state <= ENG_LOW;
                        timer <= TW'(SCK_LO - 1);
                    end else begin
                        timer <= timer - 1'b1;
                    end
                end
                ENG_LOW: begin
                    if (tdone) begin
                        state <= ENG_HIGH;
                        timer <= TW'(SCK_HI - 1);
                    end else begin
                        timer <= timer - 1'b1;
                    end
                end
                ENG_HIGH: begin
                    if (tdone) begin
                        shreg <= {shreg[FRAME_BITS-2:0], 1'b0};
                        if (!last_bit) begin
                            bit_ix <= bit_ix + 1'b1;
                            state  <= ENG_LOW;
                            timer  <= TW'(SCK_LO - 1);
                        end else if (AUTO_LOAD) begin
                            state <= ENG_LOAD;
                            timer <= TW'(LD_W - 1);
                        end else begin
                            state <= ENG_GAP;
                            timer <= '0;
                        end
                    end else begin
                        timer <= timer - 1'b1;
                    end
                end
                ENG_GAP: begin
                    state <= ENG_LOAD;
                    timer <= TW'(LD_W - 1);
                end
                ENG_LOAD: begin
                    if (tdone) begin
                        if (AUTO_LOAD) begin
                            state <= ENG_TAIL;
                            timer <= TW'(SCK_HI - 1);
                        end else begin
                            state <= ENG_IDLE;
                            done  <= 1'b1;
                        end
                    end else begin
                        timer <= timer - 1'b1;
                    end
                end
                ENG_TAIL: begin
                    if (tdone) begin
                        state <= ENG_IDLE;
                        done  <= 1'b1;
                    end else begin
                        timer <= timer - 1'b1;
                    end
                end
                default: state <= ENG_IDLE;
            endcase
        end
    end

    // Pin levels decoded from the registered phase.
    always_comb begin
        busy = (state != ENG_IDLE);
        sdo  = shreg[FRAME_BITS-1];
        if (AUTO_LOAD) begin
            sclk = !(state == ENG_LOW || state == ENG_LOAD);
            cs_n = 1'b0;
            ld_n = !(state == ENG_LOAD);
        end else begin
            sclk = (state != ENG_LOW);
            cs_n = !(state == ENG_SETUP || state == ENG_LOW || state == ENG_HIGH);
            ld_n = (state != ENG_LOAD);
        end
    end

endmodule

// File: rtl/dac_wr_ctrl.sv
// Module: dac_wr_ctrl (top)
// Host-side write and clear controller for a quad 12-bit serial DAC.
// Assumes requests are sampled on clk; timings are counts of clk cycles.
module dac_wr_ctrl
    import dac_wr_pkg::*;
#(
    parameter int SCK_LO    = 12,
    parameter int SCK_HI    = 9,
    parameter int CS_SETUP  = 9,
    parameter int LD_W      = 8,
    parameter int CLR_W     = 15,
    parameter bit AUTO_LOAD = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_req,
    input  logic [CHAN_BITS-1:0] wr_chan,
    input  logic [CODE_BITS-1:0] wr_code,
    input  logic                 clr_req,
    input  logic                 clr_mid,
    output logic                 busy,
    output logic                 done,
    output logic                 sclk,
    output logic                 sdo,
    output logic                 cs_n,
    output logic                 ld_n,
    output logic                 clr_n,
    output logic                 clsel
);
    logic [FRAME_BITS-1:0] word;

    // Frame word assembly from the request fields.
    always_comb word = pack_frame(wr_chan, wr_code);

    dac_frame_engine #(
        .SCK_LO   (SCK_LO),
        .SCK_HI   (SCK_HI),
        .CS_SETUP (CS_SETUP),
        .LD_W     (LD_W),
        .AUTO_LOAD(AUTO_LOAD)
    ) u_engine (
        .clk  (clk),
        .rst_n(rst_n),
        .start(wr_req),
        .word (word),
        .sclk (sclk),
        .sdo  (sdo),
        .cs_n (cs_n),
        .ld_n (ld_n),
        .busy (busy),
        .done (done)
    );

    dac_clear_pulser #(
        .CLR_W(CLR_W)
    ) u_clear (
        .clk  (clk),
        .rst_n(rst_n),
        .req  (clr_req),
        .mid  (clr_mid),
        .clr_n(clr_n),
        .sel  (clsel)
    );

endmodule

// File: rtl/dac_wr_ctrl_chk.sv
// Module: dac_wr_ctrl_chk
// Protocol checker bound to dac_wr_ctrl; observes ports only.
// Assumes timing parameters of at least one cycle.
module dac_wr_ctrl_chk #(
    parameter bit AUTO_LOAD = 1'b0
) (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic done,
    input logic sclk,
    input logic sdo,
    input logic cs_n,
    input logic ld_n,
    input logic clr_n,
    input logic clsel
);
    // Data holds while the clock stays high inside a selected frame (R2).
    p_sdo_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk) && !cs_n && !$past(cs_n)) |-> $stable(sdo));

    // Done is a single-cycle pulse following busy (R7).
    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_after_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    // Load strobe only inside a busy frame (R5, R6).
    p_ld_in_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_n |-> busy);

    // Preset select frozen during a clear pulse (R9).
    p_clsel_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_n && !$past(clr_n)) |-> $stable(clsel));

    generate
        if (AUTO_LOAD) begin : g_auto
            // Select never leaves low in auto-load mode (R6).
            p_cs_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
                !cs_n);
            // Load only while the clock is low (R6).
            p_ld_clk_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
                !ld_n |-> !sclk);
        end else begin : g_framed
            // Clock only goes low with select asserted (R4).
            p_sclk_low_sel_r4: assert property (@(posedge clk) disable iff (!rst_n)
                !sclk |-> !cs_n);
            // Select releases with clock high and high before (R4).
            p_cs_rise_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(cs_n) |-> (sclk && $past(sclk)));
            // Load only while deselected (R5).
            p_ld_desel_r5: assert property (@(posedge clk) disable iff (!rst_n)
                !ld_n |-> cs_n);
        end
    endgenerate

endmodule

bind dac_wr_ctrl dac_wr_ctrl_chk #(
    .AUTO_LOAD(AUTO_LOAD)
) u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .busy (busy),
    .done (done),
    .sclk (sclk),
    .sdo  (sdo),
    .cs_n (cs_n),
    .ld_n (ld_n),
    .clr_n(clr_n),
    .clsel(clsel)
);

// File: tb/dac_wr_ctrl_test.sv
// Bench: drives both variants with the same stimulus and compares every
// output on every cycle against queued expected traces built from R1..R10.
module dac_wr_ctrl_test;
    localparam time CLK_PERIOD = 10ns;
    localparam int  LO = 12, HI = 9, SU = 9, LDW = 8, CLRW = 15;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_req = 1'b0;
    logic [1:0]  wr_chan = '0;
    logic [11:0] wr_code = '0;
    logic        clr_req = 1'b0;
    logic        clr_mid = 1'b0;

    logic [1:0] o_busy, o_done, o_sclk, o_sdo, o_cs, o_ld, o_clr, o_sel;

    int n_chk = 0, n_fail = 0, dones = 0, accepts = 0;
    bit finished = 0;

    // Expected vectors {sclk,sdo,cs_n,ld_n,busy,done} and {clr_n,clsel}.
    logic [5:0] fq0[$], fq1[$];
    logic [1:0] cq0[$], cq1[$];
    logic       m_busy[2];
    logic       m_clr[2];
    logic       m_sel[2];

    always #(CLK_PERIOD/2) clk = ~clk;

    dac_wr_ctrl #(.SCK_LO(LO), .SCK_HI(HI), .CS_SETUP(SU), .LD_W(LDW),
                  .CLR_W(CLRW), .AUTO_LOAD(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_chan(wr_chan),
        .wr_code(wr_code), .clr_req(clr_req), .clr_mid(clr_mid),
        .busy(o_busy[0]), .done(o_done[0]), .sclk(o_sclk[0]), .sdo(o_sdo[0]),
        .cs_n(o_cs[0]), .ld_n(o_ld[0]), .clr_n(o_clr[0]), .clsel(o_sel[0]));

    dac_wr_ctrl #(.SCK_LO(LO), .SCK_HI(HI), .CS_SETUP(SU), .LD_W(LDW),
                  .CLR_W(CLRW), .AUTO_LOAD(1'b1)) uut_auto (
        .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_chan(wr_chan),
        .wr_code(wr_code), .clr_req(clr_req), .clr_mid(clr_mid),
        .busy(o_busy[1]), .done(o_done[1]), .sclk(o_sclk[1]), .sdo(o_sdo[1]),
        .cs_n(o_cs[1]), .ld_n(o_ld[1]), .clr_n(o_clr[1]), .clsel(o_sel[1]));

    task automatic chk(input string req, input string what, input int m,
                       input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s inst=%0d actual=%0b expected=%0b at %0t",
                     req, what, m, act, exp, $time);
        end
    endtask

    task automatic fpush(input int m, input logic [5:0] v);
        if (m == 0) fq0.push_back(v); else fq1.push_back(v);
    endtask

    // Expected frame trace per R2..R7.
    task automatic push_frame(input int m, input logic [15:0] w);
        if (m == 0) begin
            for (int k = 0; k < SU; k++) fpush(0, {1'b1, w[15], 4'b0110});
        end
        for (int b = 15; b >= 0; b--) begin
            for (int k = 0; k < LO; k++) fpush(m, {1'b0, w[b], 4'b0110});
            for (int k = 0; k < HI; k++) fpush(m, {1'b1, w[b], 4'b0110});
        end
        if (m == 0) begin
            fpush(0, 6'b101110);
            for (int k = 0; k < LDW; k++) fpush(0, 6'b101010);
            fpush(0, 6'b101101);
        end else begin
            for (int k = 0; k < LDW; k++) fpush(1, 6'b000010);
            for (int k = 0; k < HI; k++) fpush(1, 6'b100110);
            fpush(1, 6'b100101);
        end
    endtask

    task automatic tick();
        logic [5:0] e;
        logic [1:0] c;
        for (int m = 0; m < 2; m++) begin
            if (wr_req && !m_busy[m]) begin
                push_frame(m, {wr_chan, 2'b00, wr_code});
                if (m == 0) accepts++;
            end
            if (clr_req && !m_clr[m]) begin
                for (int k = 0; k < CLRW; k++)
                    if (m == 0) cq0.push_back({1'b0, clr_mid});
                    else cq1.push_back({1'b0, clr_mid});
                m_sel[m] = clr_mid;
            end
        end
        @(posedge clk);
        @(negedge clk);
        for (int m = 0; m < 2; m++) begin
            if (m == 0) e = (fq0.size() > 0) ? fq0.pop_front() : 6'b101100;
            else        e = (fq1.size() > 0) ? fq1.pop_front() : 6'b100100;
            if (m == 0) c = (cq0.size() > 0) ? cq0.pop_front() : {1'b1, m_sel[0]};
            else        c = (cq1.size() > 0) ? cq1.pop_front() : {1'b1, m_sel[1]};
            m_busy[m] = e[1];
            m_clr[m]  = !c[1];
            chk("R3", "sclk", m, o_sclk[m], e[5]);
            chk("R2", "sdo", m, o_sdo[m], e[4]);
            chk(m == 0 ? "R4" : "R6", "cs_n", m, o_cs[m], e[3]);
            chk(m == 0 ? "R5" : "R6", "ld_n", m, o_ld[m], e[2]);
            chk("R7", "busy", m, o_busy[m], e[1]);
            chk("R7", "done", m, o_done[m], e[0]);
            chk("R9", "clr_n", m, o_clr[m], c[1]);
            chk("R9", "clsel", m, o_sel[m], c[0]);
        end
        if (o_done[0] === 1'b1) dones++;
    endtask

    task automatic drain();
        while (m_busy[0] || m_busy[1] || m_clr[0] || m_clr[1]) tick();
        tick();
    endtask

    task automatic send(input logic [1:0] ch, input logic [11:0] cd);
        wr_chan = ch;
        wr_code = cd;
        wr_req  = 1'b1;
        tick();
        wr_req = 1'b0;
        drain();
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int m = 0; m < 2; m++) begin
            m_busy[m] = 1'b0; m_clr[m] = 1'b0; m_sel[m] = 1'b0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset levels in both variants.
        for (int m = 0; m < 2; m++) begin
            chk("R1", "sclk", m, o_sclk[m], 1'b1);
            chk("R1", "sdo", m, o_sdo[m], 1'b0);
            chk("R1", "cs_n", m, o_cs[m], m == 0);
            chk("R1", "ld_n", m, o_ld[m], 1'b1);
            chk("R1", "clr_n", m, o_clr[m], 1'b1);
            chk("R1", "clsel", m, o_sel[m], 1'b0);
            chk("R1", "busy", m, o_busy[m], 1'b0);
            chk("R1", "done", m, o_done[m], 1'b0);
        end
        rst_n = 1'b1;
        tick();

        // R2..R7: distinct channels and code patterns.
        send(2'd0, 12'h000);
        send(2'd1, 12'hFFF);
        send(2'd2, 12'hA5A);
        send(2'd3, 12'h5A5);
        send(2'd2, 12'h800);

        // R8: request held high across frames with changing fields.
        accepts = 0;
        dones = 0;
        wr_req = 1'b1;
        for (int k = 0; k < 900; k++) begin
            wr_chan = 2'(k);
            wr_code = 12'(k * 37);
            tick();
        end
        wr_req = 1'b0;
        drain();
        chk("R8", "done count equals accepted frames", 0, dones == accepts, 1'b1);
        chk("R8", "more than one frame accepted", 0, accepts > 1, 1'b1);

        // R9: midscale clear, a retry during the pulse is ignored, then zero.
        clr_mid = 1'b1; clr_req = 1'b1; tick();
        clr_req = 1'b0; repeat (4) tick();
        clr_mid = 1'b0; clr_req = 1'b1; tick();
        clr_req = 1'b0;
        drain();
        chk("R9", "midscale kept after ignored retry", 0, o_sel[0], 1'b1);
        clr_mid = 1'b0; clr_req = 1'b1; tick();
        clr_req = 1'b0;
        drain();
        chk("R9", "zero-scale select", 1, o_sel[1], 1'b0);

        // R10: clear in the middle of a frame.
        wr_chan = 2'd1; wr_code = 12'h3C7; wr_req = 1'b1; tick();
        wr_req = 1'b0;
        repeat (60) tick();
        clr_mid = 1'b1; clr_req = 1'b1; tick();
        clr_req = 1'b0;
        chk("R10", "frame still busy during clear", 0, o_busy[0], 1'b1);
        chk("R10", "clear pulse active mid-frame", 0, o_clr[0], 1'b0);
        drain();
        chk("R10", "clear select applied", 1, o_sel[1], 1'b1);

        finish_run();
    end

endmodule